// File: doc/BRIEF.md
# Register-Slot Receive Descriptor Ring

This block is the receive side of a DMA engine whose four receive descriptors are flip-flop registers, not structures in memory. Software arms a slot by writing one control word that holds a 16-byte aligned buffer address and an enable bit. The block takes frames from an upstream framer as a stream of data beats. It places each frame into the slot its ring index points at, writing beats through a simple write port, one word per beat at consecutive byte addresses. When the last beat arrives it stores a status word for that slot, marks the slot done, clears its enable and moves the index on by one, modulo four.

Every control word also reports the slot index the hardware will fill next. Software can therefore line up its own head pointer after a reset without having to guess. If a frame starts while the slot at the index is not armed, the frame is discarded. A drop counter increments, and the next frame that is stored carries a missed flag in its status. Framing and the CRC check happen upstream, and their results arrive as error flags on the last beat.

Top module: `rxring_top`

## Requirements
- R1: Reset clears the enable bit, the done bit and the index field of every slot, returns the ring index to 0 and zeroes the drop counter; the buffer addresses stored in the slots are kept.
- R2: A write to a slot's control word stores bits 31:4 as the buffer base, loads bit 0 as the enable and always clears the done bit; bits 3:1 of the written data are ignored. Reading a control word returns {base[31:4], index[1:0], done, enable}, with enable in bit 0 and done in bit 1.
- R3: Frames fill slots strictly in turn. The ring index advances by exactly one, modulo four (3 wraps to 0), for each stored frame, and it changes at no other time.
- R4: Bits 3:2 of every slot's control word read back the ring index that the hardware will fill next.
- R5: Beat k of a stored frame is written at byte address base + k·(DATA_W/8), with the data exactly as received. The write appears on the write port one cycle after the beat is accepted.
- R6: The clock edge that takes the last beat of a stored frame sets done and clears enable on that slot together; no slot ever shows enable and done set at the same time.
- R7: Status bits 15:0 hold the frame length in bytes, FCS included: (beats − 1)·(DATA_W/8) + the valid byte count of the last beat.
- R8: Status bits 23:17 carry the error flags present on the last beat, in this order from bit 17 upward: runt, overlength, collision, interface error, CRC error, length error, multicast.
- R9: A frame whose first beat finds the slot at the ring index not enabled is discarded. No write is issued for it, the ring index stays where it is, and the drop counter increases by one.
- R10: Status bit 16 (missed) is set in the first frame stored after one or more drops and clear in the frames after that one.
- R11: Bytes of a frame that start at or beyond MAX_BYTES are not written. The overlength flag (bit 18) is then set, and the length field still counts the whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_wr | input | 1 | Control word write strobe |
| sw_slot | input | 2 | Slot addressed by the write |
| sw_wdata | input | 32 | Buffer base (31:4) and enable (bit 0) |
| rd_slot | input | 2 | Slot addressed by the read |
| rd_sel | input | 1 | 0 reads the control word, 1 reads the status word |
| rd_data | output | 32 | Registered read data, valid one cycle after the address |
| fs_valid | input | 1 | Frame beat valid |
| fs_data | input | DATA_W | Frame beat data |
| fs_last | input | 1 | Last beat of a frame |
| fs_last_bytes | input | $clog2(DATA_W/8)+1 | Valid bytes in the last beat (1 to DATA_W/8) |
| fs_err | input | 7 | Error flags, sampled on the last beat |
| mw_en | output | 1 | Buffer write enable |
| mw_addr | output | 32 | Buffer write byte address |
| mw_data | output | DATA_W | Buffer write data |
| miss_count | output | MISS_W | Number of frames dropped because their slot was not armed |

## Verification
Most internal faults show up at the ports within one frame. If the ring index slips, the next frame's writes go to another slot's buffer base, starting on the cycle after its first beat. A wrong index also shows in bits 3:2 of any control word read on the cycle after that. A wrong enable or done bit shows either as a frame that is dropped when it should be stored, or as a frame written into a slot that was not armed. The drop counter changes on the cycle after the first beat in that case. A fault in the length or flag path only shows when the status word is read, which is one cycle after the read address is set up behind the last beat. The missed flag needs a drop and then a stored frame before any fault in it can be seen.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  localparam int SLOTS     = 4;
  localparam int SLOT_W    = 2;
  localparam int BASE_W    = 28;
  localparam int CTL_EN    = 0;
  localparam int CTL_DONE  = 1;
  localparam int ST_MISS   = 16;
  localparam int ST_ERR_LO = 17;
  localparam int N_ERR     = 7;
  localparam int ERR_OVER  = 1;

  typedef logic [SLOT_W-1:0] slot_t;

  function automatic logic [31:0] pack_status(logic [15:0] len, logic miss,
                                              logic [N_ERR-1:0] err);
    logic [31:0] w;
    w = '0;
    w[15:0] = len;
    w[ST_MISS] = miss;
    w[ST_ERR_LO +: N_ERR] = err;
    return w;
  endfunction
endpackage

// File: rtl/rxring_desc_file.sv
module rxring_desc_file
  import rxring_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sw_wr,
  input  slot_t                    sw_slot,
  input  logic [31:0]              sw_wdata,
  input  logic                     wb_valid,
  input  slot_t                    wb_slot,
  input  logic [31:0]              wb_status,
  input  slot_t                    head,
  input  slot_t                    rd_slot,
  input  logic                     rd_sel,
  output logic [31:0]              rd_data,
  output logic [SLOTS-1:0]         en_vec,
  output logic [SLOTS-1:0]         done_vec,
  output logic [BASE_W-1:0]        head_base
);
  // Base and status words carry no reset so they map onto distributed RAM.
  logic [BASE_W-1:0] base_mem [SLOTS];
  logic [31:0]       stat_mem [SLOTS];

  always_ff @(posedge clk) begin
    if (sw_wr)    base_mem[sw_slot] <= sw_wdata[31:4];
    if (wb_valid) stat_mem[wb_slot] <= wb_status;
  end

  // Flag bits: a completing frame wins over a software write on the same slot.
  for (genvar s = 0; s < SLOTS; s++) begin : g_flag
    logic en_q, done_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q   <= 1'b0;
        done_q <= 1'b0;
      end else if (wb_valid && wb_slot == slot_t'(s)) begin
        en_q   <= 1'b0;
        done_q <= 1'b1;
      end else if (sw_wr && sw_slot == slot_t'(s)) begin
        en_q   <= sw_wdata[CTL_EN];
        done_q <= 1'b0;
      end
    end
    assign en_vec[s]   = en_q;
    assign done_vec[s] = done_q;
  end

  assign head_base = base_mem[head];

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_sel) rd_data <= stat_mem[rd_slot];
    else             rd_data <= {base_mem[rd_slot], head, done_vec[rd_slot], en_vec[rd_slot]};
  end
endmodule

// File: rtl/rxring_fill_engine.sv
module rxring_fill_engine
  import rxring_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 1536,
  parameter int LEN_W     = 14,
  parameter int MISS_W    = 16,
  localparam int BPB      = DATA_W / 8,
  localparam int LB_W     = $clog2(BPB) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fs_valid,
  input  logic [DATA_W-1:0]  fs_data,
  input  logic               fs_last,
  input  logic [LB_W-1:0]    fs_last_bytes,
  input  logic [N_ERR-1:0]   fs_err,
  input  logic [SLOTS-1:0]   en_vec,
  input  logic [BASE_W-1:0]  head_base,
  output slot_t              head,
  output logic               eng_idle,
  output logic               wb_valid,
  output slot_t              wb_slot,
  output logic [31:0]        wb_status,
  output logic               mw_en,
  output logic [31:0]        mw_addr,
  output logic [DATA_W-1:0]  mw_data,
  output logic [MISS_W-1:0]  miss_count
);
  typedef enum logic [1:0] {S_IDLE, S_FILL, S_DROP} st_t;

  st_t              st_q;
  logic [31:0]      base_q;
  logic [LEN_W-1:0] off_q;
  logic             over_q, pend_q;

  logic             start, accept_new, drop_new, take, fits, over_now;
  logic [31:0]      beat_base;
  logic [LEN_W-1:0] beat_off, off_next, frame_len;
  logic [LEN_W:0]   off_sum, len_sum;
  logic [N_ERR-1:0] err_eff;

  always_comb begin
    start      = fs_valid && (st_q == S_IDLE);
    accept_new = start && en_vec[head];
    drop_new   = start && !en_vec[head];
    take       = accept_new || (fs_valid && st_q == S_FILL);
    beat_base  = (st_q == S_FILL) ? base_q : {head_base, 4'h0};
    beat_off   = (st_q == S_FILL) ? off_q : '0;
    fits       = beat_off < LEN_W'(MAX_BYTES);
    off_sum    = {1'b0, beat_off} + (LEN_W+1)'(BPB);
    off_next   = off_sum[LEN_W] ? '1 : off_sum[LEN_W-1:0];
    len_sum    = {1'b0, beat_off} + (LEN_W+1)'(fs_last_bytes);
    frame_len  = len_sum[LEN_W] ? '1 : len_sum[LEN_W-1:0];
    over_now   = ((st_q == S_FILL) && over_q) || !fits;
    err_eff    = fs_err;
    err_eff[ERR_OVER] = fs_err[ERR_OVER] | over_now;
  end

  assign wb_valid  = take && fs_last;
  assign wb_slot   = head;
  assign wb_status = pack_status(16'(frame_len), pend_q, err_eff);
  assign eng_idle  = (st_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_IDLE;
      head       <= '0;
      base_q     <= '0;
      off_q      <= '0;
      over_q     <= 1'b0;
      pend_q     <= 1'b0;
      miss_count <= '0;
      mw_en      <= 1'b0;
    end else begin
      mw_en <= take && fits;
      if (accept_new) begin
        base_q <= beat_base;
        off_q  <= off_next;
        over_q <= !fits;
        st_q   <= fs_last ? S_IDLE : S_FILL;
      end else if (drop_new) begin
        miss_count <= miss_count + 1'b1;
        pend_q     <= 1'b1;
        st_q       <= fs_last ? S_IDLE : S_DROP;
      end else if (fs_valid && st_q == S_FILL) begin
        off_q  <= off_next;
        over_q <= over_now;
        if (fs_last) st_q <= S_IDLE;
      end else if (fs_valid && fs_last && st_q == S_DROP) begin
        st_q <= S_IDLE;
      end
      if (wb_valid) begin
        head   <= head + 1'b1;
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      mw_addr <= beat_base + 32'(beat_off);
      mw_data <= fs_data;
    end
  end
endmodule

// File: rtl/rxring_top.sv
module rxring_top
  import rxring_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_BYTES = 1536,
  parameter int LEN_W     = 14,
  parameter int MISS_W    = 16,
  localparam int LB_W     = $clog2(DATA_W / 8) + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sw_wr,
  input  logic [1:0]         sw_slot,
  input  logic [31:0]        sw_wdata,
  input  logic [1:0]         rd_slot,
  input  logic               rd_sel,
  output logic [31:0]        rd_data,
  input  logic               fs_valid,
  input  logic [DATA_W-1:0]  fs_data,
  input  logic               fs_last,
  input  logic [LB_W-1:0]    fs_last_bytes,
  input  logic [6:0]         fs_err,
  output logic               mw_en,
  output logic [31:0]        mw_addr,
  output logic [DATA_W-1:0]  mw_data,
  output logic [MISS_W-1:0]  miss_count
);
  logic [SLOTS-1:0]  en_vec, done_vec;
  logic [BASE_W-1:0] head_base;
  slot_t             head, wb_slot;
  logic              wb_valid, eng_idle;
  logic [31:0]       wb_status;

  rxring_desc_file i_desc (
    .clk       (clk),
    .rst       (rst),
    .sw_wr     (sw_wr),
    .sw_slot   (sw_slot),
    .sw_wdata  (sw_wdata),
    .wb_valid  (wb_valid),
    .wb_slot   (wb_slot),
    .wb_status (wb_status),
    .head      (head),
    .rd_slot   (rd_slot),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .en_vec    (en_vec),
    .done_vec  (done_vec),
    .head_base (head_base)
  );

  rxring_fill_engine #(
    .DATA_W    (DATA_W),
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W),
    .MISS_W    (MISS_W)
  ) i_fill (
    .clk           (clk),
    .rst           (rst),
    .fs_valid      (fs_valid),
    .fs_data       (fs_data),
    .fs_last       (fs_last),
    .fs_last_bytes (fs_last_bytes),
    .fs_err        (fs_err),
    .en_vec        (en_vec),
    .head_base     (head_base),
    .head          (head),
    .eng_idle      (eng_idle),
    .wb_valid      (wb_valid),
    .wb_slot       (wb_slot),
    .wb_status     (wb_status),
    .mw_en         (mw_en),
    .mw_addr       (mw_addr),
    .mw_data       (mw_data),
    .miss_count    (miss_count)
  );
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk #(
  parameter int MISS_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        en_vec,
  input logic [3:0]        done_vec,
  input logic [1:0]        head,
  input logic              wb_valid,
  input logic [1:0]        wb_slot,
  input logic              eng_idle,
  input logic              fs_valid,
  input logic              mw_en,
  input logic [MISS_W-1:0] miss_count
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (en_vec == 4'h0 && done_vec == 4'h0 && head == 2'd0 && miss_count == '0));

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (head == $past(head) || head == $past(head) + 2'd1));

  assert_store_advances_R3: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> head == $past(head) + 2'd1);

  assert_write_follows_beat_R5: assert property (@(posedge clk) disable iff (rst)
    mw_en |-> $past(fs_valid));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    (en_vec & done_vec) == 4'h0);

  assert_store_marks_slot_R6: assert property (@(posedge clk) disable iff (rst)
    wb_valid |=> (done_vec[$past(wb_slot)] && !en_vec[$past(wb_slot)]));

  assert_drop_counts_R9: assert property (@(posedge clk) disable iff (rst)
    (fs_valid && eng_idle && !en_vec[head]) |=> miss_count == $past(miss_count) + 1'b1);

  assert_drop_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (fs_valid && eng_idle && !en_vec[head]) |=> (!mw_en && head == $past(head)));
endmodule

bind rxring_top rxring_chk #(.MISS_W(MISS_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .en_vec     (en_vec),
  .done_vec   (done_vec),
  .head       (head),
  .wb_valid   (wb_valid),
  .wb_slot    (wb_slot),
  .eng_idle   (eng_idle),
  .fs_valid   (fs_valid),
  .mw_en      (mw_en),
  .miss_count (miss_count)
);

// File: tb/test_rxring_top.sv
module test_rxring_top;
  localparam int MAXB = 1536;

  logic        clk = 1'b0;
  logic        rst;
  logic        sw_wr;
  logic [1:0]  sw_slot;
  logic [31:0] sw_wdata;
  logic [1:0]  rd_slot;
  logic        rd_sel;
  logic [31:0] rd_data;
  logic        fs_valid;
  logic [31:0] fs_data;
  logic        fs_last;
  logic [2:0]  fs_last_bytes;
  logic [6:0]  fs_err;
  logic        mw_en;
  logic [31:0] mw_addr;
  logic [31:0] mw_data;
  logic [15:0] miss_count;

  always #4 clk = ~clk;

  rxring_top i_rxring_top (
    .clk(clk), .rst(rst), .sw_wr(sw_wr), .sw_slot(sw_slot), .sw_wdata(sw_wdata),
    .rd_slot(rd_slot), .rd_sel(rd_sel), .rd_data(rd_data),
    .fs_valid(fs_valid), .fs_data(fs_data), .fs_last(fs_last),
    .fs_last_bytes(fs_last_bytes), .fs_err(fs_err),
    .mw_en(mw_en), .mw_addr(mw_addr), .mw_data(mw_data), .miss_count(miss_count)
  );

  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;
  logic [63:0] expq[$];
  logic [63:0] exp_w;

  bit          m_en[4];
  bit          m_done[4];
  logic [27:0] m_base[4];
  logic [1:0]  m_head;
  int          m_miss;
  bit          m_pend;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(int len, bit miss, logic [6:0] err);
    return {8'h00, err, miss, 16'(len)};
  endfunction

  function automatic logic [31:0] exp_ctrl(int s);
    return {m_base[s], m_head, m_done[s], m_en[s]};
  endfunction

  // Write port monitor: every write must match the next expected beat.
  always @(negedge clk) begin
    if (!rst && mw_en) begin
      if (expq.size() == 0) chk(1'b0, "R9 unexpected write", longint'(mw_addr), 0);
      else begin
        exp_w = expq.pop_front();
        chk({mw_addr, mw_data} == exp_w, "R5 write", {mw_addr, mw_data}, exp_w);
      end
    end
  end

  task automatic ctl_write(int s, logic [27:0] b, bit en);
    sw_wr = 1'b1;
    sw_slot = 2'(s);
    sw_wdata = {b, 3'($urandom), en};
    @(negedge clk);
    sw_wr = 1'b0;
    m_en[s] = en;
    m_done[s] = 1'b0;
    m_base[s] = b;
  endtask

  task automatic rd(int s, bit sel, output logic [31:0] v);
    rd_slot = 2'(s);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic frame(int nb, int lb, logic [6:0] err);
    bit          acc;
    bit          over;
    int          s;
    int          len;
    logic [31:0] base, v, es;
    logic [6:0]  e;
    s = m_head;
    acc = m_en[s];
    base = {m_base[s], 4'h0};
    for (int k = 0; k < nb; k++) begin
      fs_valid = 1'b1;
      fs_data = $urandom;
      fs_last = (k == nb - 1);
      fs_last_bytes = 3'(lb);
      fs_err = err;
      if (acc && k * 4 < MAXB) expq.push_back({base + 32'(k * 4), fs_data});
      @(negedge clk);
    end
    fs_valid = 1'b0;
    fs_last = 1'b0;
    if (acc) begin
      len = (nb - 1) * 4 + lb;
      over = ((nb - 1) * 4 >= MAXB);
      e = err;
      e[1] = e[1] | over;
      es = exp_status(len, m_pend, e);
      m_en[s] = 1'b0;
      m_done[s] = 1'b1;
      m_head = m_head + 2'd1;
      m_pend = 1'b0;
      rd(s, 1'b1, v);
      chk(v[15:0] == es[15:0], "R7 length", v[15:0], es[15:0]);
      chk(v[23:17] == es[23:17], "R8 flags", v[23:17], es[23:17]);
      chk(v[16] == es[16], "R10 missed bit", v[16], es[16]);
      rd(s, 1'b0, v);
      chk(v[1:0] == 2'b10, "R6 done/enable", v[1:0], 2'b10);
      chk(v[3:2] == m_head, "R3 ring index", v[3:2], m_head);
    end else begin
      m_miss++;
      m_pend = 1'b1;
      chk(miss_count == 16'(m_miss), "R9 drop count", miss_count, m_miss);
      rd(s, 1'b0, v);
      chk(v[3:2] == m_head, "R9 index held", v[3:2], m_head);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=stalled expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    process::self().srandom(32'h5eed_1234);
    rst = 1'b1; sw_wr = 1'b0; sw_slot = '0; sw_wdata = '0; rd_slot = '0; rd_sel = 1'b0;
    fs_valid = 1'b0; fs_data = '0; fs_last = 1'b0; fs_last_bytes = 3'd4; fs_err = '0;
    for (int s = 0; s < 4; s++) begin m_en[s] = 0; m_done[s] = 0; m_base[s] = '0; end
    m_head = '0; m_miss = 0; m_pend = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: flags, index and counter after reset
    for (int s = 0; s < 4; s++) begin
      rd(s, 1'b0, v);
      chk(v[3:0] == 4'h0, "R1 flags/index", v[3:0], 0);
    end
    chk(miss_count == 0, "R1 drop count", miss_count, 0);

    // R1: base kept across a reset, flags cleared
    for (int s = 0; s < 4; s++) ctl_write(s, 28'h0100000 + 28'(s * 'h40), 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int s = 0; s < 4; s++) begin m_en[s] = 0; m_done[s] = 0; end
    rd(2, 1'b0, v);
    chk(v == exp_ctrl(2), "R1 base kept", v, exp_ctrl(2));

    // R2: arm all four, readback
    for (int s = 0; s < 4; s++) ctl_write(s, 28'h0200000 + 28'(s * 'h80), 1'b1);
    rd(1, 1'b0, v);
    chk(v == exp_ctrl(1), "R2 readback", v, exp_ctrl(1));

    // R3: four frames fill slots 0..3 and wrap to 0
    frame(1, 1, 7'h00);
    frame(2, 4, 7'h00);
    frame(3, 2, 7'h00);
    frame(5, 3, 7'h00);
    chk(m_head == 2'd0, "R3 wrap", m_head, 0);
    // R4: every slot reports the same next index
    for (int s = 0; s < 4; s++) begin
      rd(s, 1'b0, v);
      chk(v[3:2] == m_head, "R4 index field", v[3:2], m_head);
    end

    // R9: slot 0 is done and not armed, so two frames drop
    frame(3, 4, 7'h00);
    frame(1, 2, 7'h00);

    // R10 and R8: next stored frame flags the miss, the one after does not
    ctl_write(0, 28'h0300000, 1'b1);
    frame(2, 3, 7'h55);
    ctl_write(1, 28'h0310000, 1'b1);
    frame(4, 1, 7'h2A);

    // R2: rearm of a done slot clears done
    ctl_write(0, 28'h0320000, 1'b1);
    rd(0, 1'b0, v);
    chk(v == exp_ctrl(0), "R2 rearm clears done", v, exp_ctrl(0));

    // R2: write with enable 0 leaves the slot idle
    ctl_write(2, 28'h0330000, 1'b0);
    rd(2, 1'b0, v);
    chk(v == exp_ctrl(2), "R2 disarm", v, exp_ctrl(2));
    frame(2, 2, 7'h00);

    // R11: frame longer than the buffer
    ctl_write(2, 28'h0340000, 1'b1);
    frame(386, 4, 7'h00);

    // Random mix
    for (int it = 0; it < 80; it++) begin
      for (int s = 0; s < 4; s++)
        if (!m_en[s] && ($urandom % 2 == 0)) ctl_write(s, 28'($urandom), 1'b1);
      frame(1 + int'($urandom % 6), 1 + int'($urandom % 4),
            ($urandom % 4 == 0) ? 7'($urandom) : 7'h00);
    end

    @(negedge clk);
    chk(expq.size() == 0, "R5 all writes seen", expq.size(), 0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule